// File: doc/BRIEF.md
# Single-Fetch Page Table Refill Engine

This block services a translation-buffer miss with exactly one memory read. Page table entries sit in a linear 4 MiB window of virtual space, and a base register marks where that window starts. When a miss arrives, the engine forms the address of the entry that describes the missing page. It then sends that address back through the data translation buffer as a privileged (ring 0) read. The entry address is virtual, so this lookup can hit or miss like any other access.

On a hit the engine issues one memory read at the translated physical address. When the word comes back without error, the engine writes it into the auto-refilled part of the buffer and pulses a restart to the core. If the entry address itself misses, the engine issues no memory read. It raises a miss exception for the side that started the refill (instruction or data). If the core was already in exception mode, it raises a double exception instead. A memory error on the read ends the refill with a load-error fault. Only one refill is in flight at a time, and further misses are held off until the engine is idle again.

Top module: `pt_refill_engine`

## Requirements
- R1: After reset, `miss_ready` is 1 and `xl_req_valid`, `mem_rd_valid`, `tlb_wr_en`, `restart` and `exc_valid` are all 0.
- R2: The entry address on `xl_req_va` equals the base register plus (missing VA >> 10) with bits [1:0] of the shifted value forced to 0. It appears the cycle after the miss is accepted.
- R3: Every translation request carries `xl_req_ring` = 2'b00 and `xl_req_dtlb` = 1, whether the miss came from the instruction side (`miss_side`=1) or the data side (`miss_side`=0).
- R4: A write to the base register keeps bits [31:22] of the written value and ignores bits [21:0], which read as 0 in every later entry address.
- R5: A translation hit causes exactly one memory read, with `mem_rd_addr` equal to the returned physical address, in the cycle after the hit.
- R6: A memory response without error produces a one-cycle `tlb_wr_en` carrying the returned word, the missing VA and the side, together with a one-cycle `restart`.
- R7: A translation miss of the entry address issues no memory read and pulses `exc_valid` for one cycle. `exc_code` is 0 for an instruction-side miss and 1 for a data-side miss.
- R8: When `excm` was 1 at miss acceptance, a translation miss of the entry address raises `exc_code` = 2 (double exception) instead.
- R9: A memory error response raises `exc_code` = 3 (load error) for one cycle, with no TLB write and no restart.
- R10: While a refill is in flight `miss_ready` is 0 and `miss_valid` is ignored. A miss presented only during that time starts no new refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 32 | New base value (low 22 bits ignored) |
| miss_valid | input | 1 | A TLB miss needs servicing |
| miss_side | input | 1 | 1 = instruction side, 0 = data side |
| miss_va | input | 32 | Virtual address that missed |
| excm | input | 1 | Core exception-mode bit |
| miss_ready | output | 1 | Engine idle and able to accept a miss |
| xl_req_valid | output | 1 | Translation request for the entry address |
| xl_req_va | output | 32 | Entry address to translate |
| xl_req_ring | output | 2 | Privilege ring of the request |
| xl_req_dtlb | output | 1 | Request goes through the data TLB |
| xl_rsp_valid | input | 1 | Translation response |
| xl_rsp_hit | input | 1 | Entry address translated |
| xl_rsp_pa | input | 32 | Physical address of the entry |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Physical read address |
| mem_rsp_valid | input | 1 | Memory read response |
| mem_rsp_err | input | 1 | Memory error on the read |
| mem_rsp_data | input | 32 | Entry word returned |
| tlb_wr_en | output | 1 | Write the entry into the TLB |
| tlb_wr_va | output | 32 | Missing VA being filled |
| tlb_wr_pte | output | 32 | Entry word to install |
| tlb_wr_side | output | 1 | Side the fill belongs to |
| restart | output | 1 | Restart the original access |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 0 instr miss, 1 data miss, 2 double, 3 load error |

## Verification
The bench sweeps side, exception-mode bit and outcome (translation miss, memory error, good fill) across several bases and addresses. This covers the top address, where base plus offset reaches the last word of the window. A design that dropped the two-bit masking or shifted by the wrong amount would fetch the wrong entry. One that kept the low base bits would land inside the window rather than at its start. Mixing up the side would raise the wrong miss code, and ignoring the exception-mode bit would lose the double exception. Holding a second miss during the memory wait exposes a design that accepts work while busy and would start a second refill.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XLATE = 3'd1,
    ST_READ  = 3'd2,
    ST_FILL  = 3'd3,
    ST_FAULT = 3'd4
  } ptr_state_e;

  typedef enum logic [1:0] {
    EXC_IMISS  = 2'd0,
    EXC_DMISS  = 2'd1,
    EXC_DOUBLE = 2'd2,
    EXC_LDERR  = 2'd3
  } ptr_exc_e;
endpackage

// File: rtl/ptr_base_reg.sv
module ptr_base_reg #(
  parameter int VA_W     = 32,
  parameter int SPAN_LG2 = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [VA_W-1:0] wr_data,
  output logic [VA_W-1:0] base
);
  localparam logic [VA_W-1:0] KEEP_MASK = {{(VA_W-SPAN_LG2){1'b1}}, {SPAN_LG2{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else if (wr_en) base <= wr_data & KEEP_MASK;
  end

  // R4: upper bits follow the write, window offset bits stay clear
  p_base_write_r4: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (base == ($past(wr_data) & KEEP_MASK)));
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int VA_W     = 32,
  parameter int PAGE_LG2 = 12,
  parameter int PTE_LG2  = 2
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] entry_addr
);
  localparam int SHIFT = PAGE_LG2 - PTE_LG2;
  localparam logic [VA_W-1:0] LOW_CLR = ~((VA_W'(1) << PTE_LG2) - VA_W'(1));

  always_comb entry_addr = base + ((va >> SHIFT) & LOW_CLR);
endmodule

// File: rtl/ptr_fsm.sv
module ptr_fsm
  import ptr_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  input  logic             miss_side,
  input  logic [VA_W-1:0]  miss_va,
  input  logic             excm,
  input  logic [VA_W-1:0]  entry_addr,
  output logic             miss_ready,
  output logic             xl_req_valid,
  output logic [VA_W-1:0]  xl_req_va,
  input  logic             xl_rsp_valid,
  input  logic             xl_rsp_hit,
  input  logic [PA_W-1:0]  xl_rsp_pa,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             tlb_wr_en,
  output logic [VA_W-1:0]  tlb_wr_va,
  output logic [PTE_W-1:0] tlb_wr_pte,
  output logic             tlb_wr_side,
  output logic             restart,
  output logic             exc_valid,
  output logic [1:0]       exc_code
);
  ptr_state_e state;
  logic       excm_q;

  assign miss_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      excm_q       <= 1'b0;
      xl_req_valid <= 1'b0;
      xl_req_va    <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      tlb_wr_en    <= 1'b0;
      tlb_wr_va    <= '0;
      tlb_wr_pte   <= '0;
      tlb_wr_side  <= 1'b0;
      restart      <= 1'b0;
      exc_valid    <= 1'b0;
      exc_code     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (miss_valid) begin
          tlb_wr_va    <= miss_va;
          tlb_wr_side  <= miss_side;
          excm_q       <= excm;
          xl_req_valid <= 1'b1;
          xl_req_va    <= entry_addr;
          state        <= ST_XLATE;
        end
        ST_XLATE: if (xl_rsp_valid) begin
          xl_req_valid <= 1'b0;
          if (xl_rsp_hit) begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= xl_rsp_pa;
            state        <= ST_READ;
          end else begin
            exc_valid <= 1'b1;
            exc_code  <= excm_q ? EXC_DOUBLE : (tlb_wr_side ? EXC_IMISS : EXC_DMISS);
            state     <= ST_FAULT;
          end
        end
        ST_READ: if (mem_rsp_valid) begin
          mem_rd_valid <= 1'b0;
          if (mem_rsp_err) begin
            exc_valid <= 1'b1;
            exc_code  <= EXC_LDERR;
            state     <= ST_FAULT;
          end else begin
            tlb_wr_en  <= 1'b1;
            tlb_wr_pte <= mem_rsp_data;
            restart    <= 1'b1;
            state      <= ST_FILL;
          end
        end
        ST_FILL: begin
          tlb_wr_en <= 1'b0;
          restart   <= 1'b0;
          state     <= ST_IDLE;
        end
        ST_FAULT: begin
          exc_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: one refill phase active at a time
  p_one_phase_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xl_req_valid, mem_rd_valid, tlb_wr_en, exc_valid}));
  // R5 / R7: a memory read only follows a translation hit
  p_read_after_hit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_valid) |-> $past(xl_rsp_valid && xl_rsp_hit));
  // R6 / R9: fill only after an error-free memory response
  p_fill_after_ok_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tlb_wr_en) |-> $past(mem_rsp_valid && !mem_rsp_err));
  // R7 / R8 / R9: an exception follows a translation miss or a memory error
  p_exc_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(exc_valid) |-> ($past(xl_rsp_valid && !xl_rsp_hit) || $past(mem_rsp_valid && mem_rsp_err)));
endmodule

// File: rtl/pt_refill_engine.sv
module pt_refill_engine #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int PAGE_LG2 = 12,
  parameter int PTE_LG2  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_wr_en,
  input  logic [VA_W-1:0]  base_wr_data,
  input  logic             miss_valid,
  input  logic             miss_side,
  input  logic [VA_W-1:0]  miss_va,
  input  logic             excm,
  output logic             miss_ready,
  output logic             xl_req_valid,
  output logic [VA_W-1:0]  xl_req_va,
  output logic [1:0]       xl_req_ring,
  output logic             xl_req_dtlb,
  input  logic             xl_rsp_valid,
  input  logic             xl_rsp_hit,
  input  logic [PA_W-1:0]  xl_rsp_pa,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             tlb_wr_en,
  output logic [VA_W-1:0]  tlb_wr_va,
  output logic [PTE_W-1:0] tlb_wr_pte,
  output logic             tlb_wr_side,
  output logic             restart,
  output logic             exc_valid,
  output logic [1:0]       exc_code
);
  localparam int SPAN_LG2 = VA_W - PAGE_LG2 + PTE_LG2;

  logic [VA_W-1:0] base;
  logic [VA_W-1:0] entry_addr;

  assign xl_req_ring = 2'b00;
  assign xl_req_dtlb = 1'b1;

  ptr_base_reg #(.VA_W(VA_W), .SPAN_LG2(SPAN_LG2)) u_base (
    .clk(clk), .rst(rst), .wr_en(base_wr_en), .wr_data(base_wr_data), .base(base)
  );

  ptr_addr_gen #(.VA_W(VA_W), .PAGE_LG2(PAGE_LG2), .PTE_LG2(PTE_LG2)) u_addr (
    .base(base), .va(miss_va), .entry_addr(entry_addr)
  );

  ptr_fsm #(.VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_fsm (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_side(miss_side), .miss_va(miss_va), .excm(excm),
    .entry_addr(entry_addr), .miss_ready(miss_ready),
    .xl_req_valid(xl_req_valid), .xl_req_va(xl_req_va),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_hit(xl_rsp_hit), .xl_rsp_pa(xl_rsp_pa),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_va(tlb_wr_va), .tlb_wr_pte(tlb_wr_pte),
    .tlb_wr_side(tlb_wr_side), .restart(restart),
    .exc_valid(exc_valid), .exc_code(exc_code)
  );
endmodule

// File: tb/test_pt_refill_engine.sv
`timescale 1ns/1ps
module test_pt_refill_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        miss_valid = 1'b0;
  logic        miss_side = 1'b0;
  logic [31:0] miss_va = '0;
  logic        excm = 1'b0;
  logic        miss_ready;
  logic        xl_req_valid;
  logic [31:0] xl_req_va;
  logic [1:0]  xl_req_ring;
  logic        xl_req_dtlb;
  logic        xl_rsp_valid = 1'b0;
  logic        xl_rsp_hit = 1'b0;
  logic [31:0] xl_rsp_pa = '0;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tlb_wr_en;
  logic [31:0] tlb_wr_va;
  logic [31:0] tlb_wr_pte;
  logic        tlb_wr_side;
  logic        restart;
  logic        exc_valid;
  logic [1:0]  exc_code;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] base_exp = '0;

  always #2 clk = ~clk;

  pt_refill_engine i_pt_refill_engine (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] w);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = w;
    @(negedge clk);
    base_wr_en = 1'b0;
    base_exp = w & 32'hFFC0_0000;
  endtask

  // outcome: 0 translation miss, 1 memory error, 2 good fill
  task automatic refill(input logic [31:0] va, input bit side, input bit em, input int outcome);
    logic [31:0] exp_ent;
    logic [31:0] pa;
    logic [31:0] pte;
    exp_ent = base_exp + ((va >> 10) & 32'hFFFF_FFFC);
    pa  = va ^ 32'h5A5A_0F0C;
    pte = ~va;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R10", "ready when idle", 64'(miss_ready), 64'd1);
    miss_valid = 1'b1; miss_side = side; miss_va = va; excm = em;
    @(negedge clk);
    miss_valid = 1'b0; miss_va = '0; excm = 1'b0; miss_side = 1'b0;
    chk(xl_req_valid == 1'b1, "R2", "xlate request", 64'(xl_req_valid), 64'd1);
    chk(xl_req_va == exp_ent, "R2", "entry address", 64'(xl_req_va), 64'(exp_ent));
    chk(xl_req_ring == 2'b00 && xl_req_dtlb == 1'b1, "R3", "ring0 data tlb",
        64'({xl_req_ring, xl_req_dtlb}), 64'(3'b001));
    chk(miss_ready == 1'b0, "R10", "busy during xlate", 64'(miss_ready), 64'd0);
    xl_rsp_valid = 1'b1; xl_rsp_hit = (outcome != 0); xl_rsp_pa = pa;
    @(negedge clk);
    xl_rsp_valid = 1'b0; xl_rsp_hit = 1'b0;
    if (outcome == 0) begin
      logic [1:0] ec;
      ec = em ? 2'd2 : (side ? 2'd0 : 2'd1);
      chk(mem_rd_valid == 1'b0, "R7", "no read on miss", 64'(mem_rd_valid), 64'd0);
      chk(exc_valid == 1'b1, "R7", "exception pulse", 64'(exc_valid), 64'd1);
      chk(exc_code == ec, em ? "R8" : "R7", "exception code", 64'(exc_code), 64'(ec));
      chk(tlb_wr_en == 1'b0 && restart == 1'b0, "R7", "no fill on miss",
          64'({tlb_wr_en, restart}), 64'd0);
    end else begin
      chk(mem_rd_valid == 1'b1 && mem_rd_addr == pa, "R5", "read at translated pa",
          64'({mem_rd_valid, mem_rd_addr}), 64'({1'b1, pa}));
      // R10: a miss offered while busy must be ignored
      miss_valid = 1'b1; miss_va = va ^ 32'hFFFF_F000; miss_side = ~side;
      @(negedge clk);
      chk(miss_ready == 1'b0, "R10", "busy during read", 64'(miss_ready), 64'd0);
      chk(mem_rd_valid == 1'b1, "R5", "read held until response", 64'(mem_rd_valid), 64'd1);
      miss_valid = 1'b0; miss_va = '0; miss_side = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_err = (outcome == 1); mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      chk(mem_rd_valid == 1'b0, "R5", "single read", 64'(mem_rd_valid), 64'd0);
      if (outcome == 1) begin
        chk(exc_valid == 1'b1 && exc_code == 2'd3, "R9", "load error",
            64'({exc_valid, exc_code}), 64'(3'b111));
        chk(tlb_wr_en == 1'b0 && restart == 1'b0, "R9", "no fill on error",
            64'({tlb_wr_en, restart}), 64'd0);
      end else begin
        chk(tlb_wr_en == 1'b1 && restart == 1'b1 && exc_valid == 1'b0, "R6", "fill strobes",
            64'({tlb_wr_en, restart, exc_valid}), 64'(3'b110));
        chk(tlb_wr_pte == pte && tlb_wr_va == va && tlb_wr_side == side, "R6", "fill contents",
            64'({tlb_wr_side, tlb_wr_pte}), 64'({side, pte}));
      end
    end
    @(negedge clk);
    chk(exc_valid == 1'b0 && tlb_wr_en == 1'b0 && restart == 1'b0, "R6", "pulses one cycle",
        64'({exc_valid, tlb_wr_en, restart}), 64'd0);
    chk(miss_ready == 1'b1 && xl_req_valid == 1'b0, "R10", "idle, no second refill",
        64'({miss_ready, xl_req_valid}), 64'(2'b10));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(miss_ready == 1'b1, "R1", "ready after reset", 64'(miss_ready), 64'd1);
    chk({xl_req_valid, mem_rd_valid, tlb_wr_en, restart, exc_valid} == 5'b0, "R1",
        "outputs idle after reset",
        64'({xl_req_valid, mem_rd_valid, tlb_wr_en, restart, exc_valid}), 64'd0);
    // R4: low base bits ignored, seen through the entry address of va 0
    set_base(32'h8A3F_FFFF);
    refill(32'h0000_0000, 1'b0, 1'b0, 2);
    // boundary: top of the window
    set_base(32'hFFC0_0000);
    refill(32'hFFFF_FFFF, 1'b1, 1'b0, 2);
    for (int b = 0; b < 3; b++) begin
      set_base((32'h1234_5678 * (b + 1)) ^ 32'h003F_FFFF);
      for (int v = 0; v < 4; v++) begin
        logic [31:0] va;
        va = (32'(v) * 32'h9E37_79B9) ^ (32'(b) << 28) ^ 32'h0000_0ABC;
        for (int s = 0; s < 2; s++)
          for (int e = 0; e < 2; e++)
            for (int o = 0; o < 3; o++)
              refill(va, s[0], e[0], o);
      end
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule